// File: doc/BRIEF.md
# Flywheel Toggle Aligner

This block generates a square-wave toggle with a fixed period, counted in clock cycles, in a single clock domain. The toggle keeps running by itself, like a flywheel, and it can be phase-locked to a toggle that arrives from elsewhere. A mode input decides whether that lock is applied. While the mode input is high, every level change seen on the incoming toggle sets the output phase. While it is low, the output keeps its own period and phase and pays no attention to the incoming toggle.

A typical use is to regenerate a clean periodic strobe from an incoming toggle that may glitch or stop. The incoming toggle must already be synchronous to the clock. Lock is enabled while the source is known to be good. After that the output keeps running without the source. Optional register stages at the output add latency where timing closure needs it.

Top module: `toggle_flywheel`

## Requirements
- R1: While `rst` is high, `tog_out` is 0 at every clock edge. After reset is released, the internal phase counter starts from zero.
- R2: When no incoming edge is accepted, `tog_out` inverts once every PERIOD/2 cycles, in either mode. This also applies when `tog_in` has stopped.
- R3: With `align_en` high, a change of `tog_in` sampled at a clock edge sets `tog_out` to the new `tog_in` level at that same edge (PIPE_STAGES = 0). The next inversion then follows PERIOD/2 cycles later.
- R4: With `align_en` high, a one-cycle phase slip on `tog_in` moves `tog_out` to the slipped phase at the first edge of the slipped input.
- R5: With `align_en` low, changes on `tog_in` have no effect. `tog_out` keeps the period and phase it already had, including through a slip of the input.
- R6: When `align_en` returns high after a period with it low, the first `tog_in` change sets `tog_out` to the incoming phase.
- R7: PIPE_STAGES adds exactly that many cycles of latency to `tog_out`. Each added stage clears to 0 on reset.
- R8: PERIOD must be even and at least 2. Any other value stops elaboration with an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| align_en | input | 1 | 1 = lock the output phase to `tog_in` edges, 0 = free-run and ignore `tog_in` |
| tog_in | input | 1 | Incoming toggle, synchronous to `clk` |
| tog_out | output | 1 | Regenerated toggle with a period of PERIOD cycles |

## Verification
The incoming toggle is driven at the nominal half period, with a single extra cycle of delay inserted into it, and finally held constant. Each of these patterns is applied with locking enabled and with it disabled. A steady toggle shows whether lock happens with zero added latency. The inserted slip separates a design that follows the new phase from one that holds the old phase, and which behaviour appears must depend on the mode input. A held input shows that the flywheel inverts on its own at the configured interval. A second instance with two output stages is compared with the first, delayed by two cycles.

// File: rtl/tfw_pkg.sv
package tfw_pkg;
  // width of a counter that must hold values 0 .. n-1 (at least 1 bit)
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tfw_edge.sv
module tfw_edge (
  input  logic clk,
  input  logic rst,
  input  logic tog_in,
  output logic edge_seen
);
  logic tog_q;

  always_ff @(posedge clk) begin
    if (rst) tog_q <= 1'b0;
    else     tog_q <= tog_in;
  end

  assign edge_seen = tog_in ^ tog_q;
endmodule

// File: rtl/tfw_core.sv
module tfw_core #(
  parameter int unsigned PERIOD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic align_en,
  input  logic tog_in,
  input  logic edge_seen,
  output logic phase_out
);
  import tfw_pkg::*;

  localparam int unsigned HALF = PERIOD / 2;
  localparam int unsigned CW   = cnt_width(HALF);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  // R8: reject unusable periods at elaboration
  generate
    if ((PERIOD < 2) || ((PERIOD % 2) != 0)) begin : g_bad_period
      $error("tfw_core: PERIOD must be even and >= 2");
    end
  endgenerate

  logic [CW-1:0] cnt;
  logic          relock;

  assign relock = align_en & edge_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      phase_out <= 1'b0;
    end else if (relock) begin
      cnt       <= '0;
      phase_out <= tog_in;
    end else if (cnt == LAST) begin
      cnt       <= '0;
      phase_out <= ~phase_out;
    end else begin
      cnt       <= cnt + 1'b1;
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (phase_out == 1'b0 && cnt == '0));

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  p_flip_r2: assert property (@(posedge clk) disable iff (rst)
    (!relock && cnt == LAST) |=> (phase_out != $past(phase_out)));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!align_en && cnt != LAST) |=> $stable(phase_out));

  p_follow_r3: assert property (@(posedge clk) disable iff (rst)
    relock |=> (phase_out == $past(tog_in)));
endmodule

// File: rtl/tfw_pipe.sv
module tfw_pipe #(
  parameter int unsigned STAGES = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_regs
      logic [STAGES-1:0] sr;
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst) sr[i] <= 1'b0;
          else if (i == 0) sr[i] <= din;
          else sr[i] <= sr[(i == 0) ? 0 : i-1];
        end
      end
      assign dout = sr[STAGES-1];

      p_pipe_reset_r7: assert property (@(posedge clk)
        rst |=> (dout == 1'b0));
    end
  endgenerate
endmodule

// File: rtl/toggle_flywheel.sv
module toggle_flywheel #(
  parameter int unsigned PERIOD      = 4,
  parameter int unsigned PIPE_STAGES = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic align_en,
  input  logic tog_in,
  output logic tog_out
);
  logic edge_seen;
  logic phase;

  tfw_edge u_edge (
    .clk       (clk),
    .rst       (rst),
    .tog_in    (tog_in),
    .edge_seen (edge_seen)
  );

  tfw_core #(.PERIOD(PERIOD)) u_core (
    .clk       (clk),
    .rst       (rst),
    .align_en  (align_en),
    .tog_in    (tog_in),
    .edge_seen (edge_seen),
    .phase_out (phase)
  );

  tfw_pipe #(.STAGES(PIPE_STAGES)) u_pipe (
    .clk  (clk),
    .rst  (rst),
    .din  (phase),
    .dout (tog_out)
  );
endmodule

// File: tb/toggle_flywheel_test.sv
`timescale 1ns/1ps
module toggle_flywheel_test;
  localparam int unsigned PERIOD = 4;
  localparam int unsigned HALF   = PERIOD / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic align_en = 1'b1;
  logic tog_in = 1'b0;
  logic tog_out, tog_out_p2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench expectation state, built from the requirements
  logic   e_lvl = 1'b0;
  int     e_age = 0;
  logic   e_prev = 1'b0;
  logic   q1 = 1'b0, q2 = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  toggle_flywheel #(.PERIOD(PERIOD), .PIPE_STAGES(0)) uut (
    .clk(clk), .rst(rst), .align_en(align_en), .tog_in(tog_in), .tog_out(tog_out));

  toggle_flywheel #(.PERIOD(PERIOD), .PIPE_STAGES(2)) uut_p2 (
    .clk(clk), .rst(rst), .align_en(align_en), .tog_in(tog_in), .tog_out(tog_out_p2));

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, let the edge pass, compare at next negedge
  task automatic step(input logic a, input logic t, input string tag, input bit direct);
    logic lvl_prev;
    align_en = a;
    tog_in   = t;
    @(posedge clk);
    lvl_prev = e_lvl;
    if (a && (t != e_prev)) begin
      e_lvl = t; e_age = 0;                 // R3: lock to input edge
    end else if (e_age == HALF - 1) begin
      e_lvl = ~e_lvl; e_age = 0;            // R2: flywheel inversion
    end else begin
      e_age++;
    end
    e_prev = t;
    q2 = q1; q1 = lvl_prev;
    @(negedge clk);
    check(tag, tog_out, e_lvl);
    check("R7", tog_out_p2, q2);
    if (direct) check(tag, tog_out, t);
  endtask

  task automatic run_toggles(input logic a, input int n, input string tag, input bit direct);
    for (int i = 0; i < n; i++) begin
      logic nt;
      nt = ~tog_in;
      for (int k = 0; k < HALF; k++) step(a, nt, tag, direct);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", tog_out, 1'b0);
    check("R1", tog_out_p2, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_align_lock();
    run_toggles(1'b1, 10, "R3", 1'b1);
  endtask

  task automatic t_align_slip();
    step(1'b1, tog_in, "R4", 1'b0);     // one extra cycle on the input
    run_toggles(1'b1, 10, "R4", 1'b1);  // output must follow the new phase
  endtask

  task automatic t_maintain();
    run_toggles(1'b0, 10, "R5", 1'b0);
    step(1'b0, tog_in, "R5", 1'b0);     // slip while maintaining
    run_toggles(1'b0, 10, "R5", 1'b0);
  endtask

  task automatic t_realign();
    logic nt;
    nt = ~tog_in;
    step(1'b1, nt, "R6", 1'b1);         // first edge takes over the phase
    for (int k = 1; k < HALF; k++) step(1'b1, nt, "R6", 1'b1);
    run_toggles(1'b1, 9, "R6", 1'b1);
  endtask

  task automatic t_stopped(input logic a);
    int   flips;
    logic last;
    flips = 0;
    last  = tog_out;
    for (int i = 0; i < 4 * HALF; i++) begin
      step(a, tog_in, "R2", 1'b0);
      if (tog_out != last) flips++;
      last = tog_out;
    end
    checks++;
    if (flips != 4) begin
      errors++;
      $display("FAIL R2: actual %0d inversions expected 4", flips);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_stopped(1'b1);
    t_align_lock();
    t_align_slip();
    t_maintain();
    t_realign();
    t_stopped(1'b1);
    t_stopped(1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule